// File: doc/BRIEF.md
# Latched Interrupt Flag with One-Deep Pending Event

This block sits after the event-trigger stage of a PWM channel. It turns incoming event strobes into single-cycle interrupt pulses, and the same pulse also serves as a DMA request. Each pulse sets a sticky status flag. While that flag is set, the block sends out no further pulses. Instead it remembers at most one further event as pending and discards any others. Software reads the flag through a read-only 16-bit status register. It writes a one to bit 0 of a separate 16-bit clear register to drop the flag. Dropping the flag re-opens the pulse path, and a pending event, if there is one, goes out at once.

The event strobe and the pulse are plain control pins with no handshake. The strobe is taken as a one-cycle event whenever it is high at a clock edge. The pulse carries no ready: a downstream interrupt controller or DMA engine must accept it in the cycle it is high, because no back-pressure is possible. The register bus is a simple strobe bus. A write or read is accepted in the cycle its enable is high. Read data comes back one cycle later.

Top module: `irq_latch_pend`

## Requirements
- R1: After a synchronous active-high reset, the flag is 0, nothing is pending, `irq_pulse` is 0 and `bus_rdata` is 0.
- R2: An event strobe at a clock edge while the flag is 0 raises `irq_pulse` for exactly one cycle, starting at the next cycle. From that same cycle, bit 0 of the status register (byte address 0) reads 1.
- R3: While the flag is 1 and no clear write happens, event strobes produce no pulse.
- R4: While the flag is 1, one event is held as pending and any further events are dropped. After one clear, exactly one pulse is issued. A second clear with no new events leaves no pulse and the flag at 0.
- R5: A write with data bit 0 = 1 to the clear register (byte address 2) clears the flag. If an event is pending, its pulse appears in the cycle after the write, the flag reads 1 again, and the pending state is emptied.
- R6: A write with data bit 0 = 0 to the clear register has no effect. Any write to the status register has no effect.
- R7: Read data appears in the cycle after a read enable and is 0 in cycles with no read. Bits 15 to 1 of the status register read 0. The clear register always reads 0. Unmapped addresses read 0.
- R8: If a clear write and an event strobe fall in the same cycle, the event wins. A pulse appears in the next cycle, the flag remains 1, and nothing extra is left pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_strobe | input | 1 | Interrupt event from the event-trigger stage, one event per high cycle |
| irq_pulse | output | 1 | One-cycle interrupt / DMA request pulse |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register byte address (status 0, clear 2) |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data, valid the cycle after `bus_rd_en` |

## Verification
The block holds two bits of state, the flag and the pending mark, so any corruption shows at the ports within one or two cycles. A stuck or lost flag shows up in the next status read, and it also lets a pulse through while events should be held back. A lost pending mark only shows up at the next clear, as a missing pulse in the following cycle. A pending mark that is never emptied shows up as a second pulse after a later clear. Comparing against a cycle-level model on every clock therefore catches a wrong state no later than the first clear or read that depends on it.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_CLEAR = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic flag;
    logic pend;
    logic pulse;
  } latch_state_t;

endpackage

// File: rtl/irq_regbus.sv
module irq_regbus
  import irq_latch_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 4,
  parameter int STAT_ADDR  = 0,
  parameter int CLEAR_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag,
  output logic              clr_hit,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] CLEAR_A = ADDR_W'(CLEAR_ADDR);

  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rdata_q;
  logic              wdata_unused_hi;

  always_comb begin
    if (addr == STAT_A)       sel = SEL_STAT;
    else if (addr == CLEAR_A) sel = SEL_CLEAR;
    else                      sel = SEL_NONE;
  end

  // Only bit 0 of the clear register acts; status writes are dropped.
  assign clr_hit = wr_en && (sel == SEL_CLEAR) && wdata[0];
  assign wdata_unused_hi = ^wdata[DATA_W-1:1];

  // Status word: flag in bit 0, reserved bits forced low.
  for (genvar b = 0; b < DATA_W; b++) begin : g_rd_bit
    if (b == 0) begin : g_flag
      assign rd_word[b] = (sel == SEL_STAT) && flag;
    end else begin : g_rsvd
      assign rd_word[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_word;
    else            rdata_q <= '0;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/irq_flag_core.sv
module irq_flag_core
  import irq_latch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic clr_hit,
  output logic flag,
  output logic pend,
  output logic pulse
);

  latch_state_t st_q, st_d;
  logic         slot_open;
  logic         have_src;

  // The issue slot is open when no flag is held or it is being cleared.
  assign slot_open = !st_q.flag || clr_hit;
  assign have_src  = st_q.pend || evt;

  always_comb begin
    st_d = st_q;
    st_d.pulse = 1'b0;
    if (slot_open) begin
      if (have_src) begin
        st_d.pulse = 1'b1;
        st_d.flag  = 1'b1;
        // Pending goes out first; a coincident new event takes its place.
        st_d.pend  = st_q.pend && evt;
      end else begin
        st_d.flag  = 1'b0;
      end
    end else if (evt) begin
      st_d.pend = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

  assign flag  = st_q.flag;
  assign pend  = st_q.pend;
  assign pulse = st_q.pulse;

endmodule

// File: rtl/irq_latch_pend.sv
module irq_latch_pend #(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 4,
  parameter int STAT_ADDR  = 0,
  parameter int CLEAR_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_strobe,
  output logic              irq_pulse,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  logic flag_q;
  logic pend_q;
  logic clr_hit;

  irq_regbus #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .STAT_ADDR (STAT_ADDR),
    .CLEAR_ADDR(CLEAR_ADDR)
  ) u_regbus (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_wr_en),
    .rd_en  (bus_rd_en),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .flag   (flag_q),
    .clr_hit(clr_hit),
    .rdata  (bus_rdata)
  );

  irq_flag_core u_core (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt_strobe),
    .clr_hit(clr_hit),
    .flag   (flag_q),
    .pend   (pend_q),
    .pulse  (irq_pulse)
  );

endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk #(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 4,
  parameter int CLEAR_ADDR = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              evt,
  input logic              flag,
  input logic              pend,
  input logic              clr_hit,
  input logic              pulse,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!pulse && !flag && !pend && rdata == '0));

  assert_pulse_sets_flag_R2: assert property (@(posedge clk) disable iff (rst)
    pulse |-> flag);

  assert_event_issues_R2: assert property (@(posedge clk) disable iff (rst)
    (evt && !flag) |=> pulse);

  assert_held_no_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_hit) |=> (!pulse && flag));

  assert_held_event_pends_R4: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_hit && evt) |=> pend);

  assert_pending_issued_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && pend) |=> (pulse && flag));

  assert_clear_drops_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && !pend && !evt) |=> (!flag && !pulse));

  assert_clear_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(CLEAR_ADDR)) |=> (rdata == '0));

  assert_idle_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (rst)
    rdata[DATA_W-1:1] == '0);

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && evt) |=> (pulse && flag));

endmodule

bind irq_latch_pend irq_latch_chk #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .CLEAR_ADDR(CLEAR_ADDR)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .evt    (evt_strobe),
  .flag   (flag_q),
  .pend   (pend_q),
  .clr_hit(clr_hit),
  .pulse  (irq_pulse),
  .rd_en  (bus_rd_en),
  .addr   (bus_addr),
  .rdata  (bus_rdata)
);

// File: tb/test_irq_latch_pend.sv
`timescale 1ns/1ps
module test_irq_latch_pend;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt = 1'b0;
  logic        wr  = 1'b0;
  logic        rd  = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        pulse;
  logic [15:0] rdata;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // Reference model state
  int m_flag = 0, m_pend = 0, m_pulse = 0, m_rd = 0;

  always #2 clk = ~clk;

  irq_latch_pend i_irq_latch_pend (
    .clk(clk), .rst(rst), .evt_strobe(evt), .irq_pulse(pulse),
    .bus_wr_en(wr), .bus_rd_en(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata)
  );

  always @(posedge clk) begin
    int clr, open;
    if (rst) begin
      m_flag = 0; m_pend = 0; m_pulse = 0; m_rd = 0;
    end else begin
      clr  = (wr && addr == 4'd2 && wdata[0]) ? 1 : 0;
      m_rd = (rd && addr == 4'd0) ? m_flag : 0;
      open = (m_flag == 0 || clr == 1) ? 1 : 0;
      if (open == 1 && (m_pend == 1 || evt)) begin
        m_pulse = 1; m_flag = 1;
        m_pend = (m_pend == 1 && evt) ? 1 : 0;
      end else begin
        m_pulse = 0;
        if (open == 1) m_flag = 0;
        else if (evt) m_pend = 1;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(cur_req, "model pulse", int'(pulse), m_pulse);
      check(cur_req, "model rdata", int'(rdata), m_rd);
    end
  end

  task automatic cyc(bit e, bit w, bit r, logic [3:0] a, logic [15:0] d);
    evt = e; wr = w; rd = r; addr = a; wdata = d;
    @(negedge clk);
    evt = 0; wr = 0; rd = 0; addr = '0; wdata = '0;
  endtask

  task automatic read_reg(logic [3:0] a, output int v);
    cyc(0, 0, 1, a, '0);
    v = int'(rdata);
  endtask

  initial begin
    #200000;
    $display("FAIL watchdog actual=timeout expected=finish");
    fails++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v;
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1", "pulse after reset", int'(pulse), 0);
    check("R1", "rdata after reset", int'(rdata), 0);
    read_reg(4'd0, v); check("R1", "flag after reset", v, 0);

    // R2: single event
    cur_req = "R2";
    cyc(1, 0, 0, 4'd0, '0);
    check("R2", "pulse after event", int'(pulse), 1);
    cyc(0, 0, 0, 4'd0, '0);
    check("R2", "pulse one cycle", int'(pulse), 0);
    read_reg(4'd0, v); check("R2", "flag set", v, 1);

    // R3/R4: events while held
    cur_req = "R3";
    for (int i = 0; i < 3; i++) begin
      cyc(1, 0, 0, 4'd0, '0);
      check("R3", "no pulse while held", int'(pulse), 0);
    end
    // R6: write 0 to clear
    cur_req = "R6";
    cyc(0, 1, 0, 4'd2, 16'hFFFE);
    check("R6", "no pulse on zero clear", int'(pulse), 0);
    read_reg(4'd0, v); check("R6", "flag kept on zero clear", v, 1);
    read_reg(4'd2, v); check("R7", "clear reg reads zero", v, 0);
    // R5: clear releases pending
    cur_req = "R5";
    cyc(0, 1, 0, 4'd2, 16'h0001);
    check("R5", "pending pulse after clear", int'(pulse), 1);
    read_reg(4'd0, v); check("R5", "flag set again", v, 1);
    cur_req = "R4";
    cyc(0, 1, 0, 4'd2, 16'h0001);
    check("R4", "extra events dropped", int'(pulse), 0);
    read_reg(4'd0, v); check("R4", "flag cleared", v, 0);

    // R8: clear and event together
    cur_req = "R8";
    cyc(1, 0, 0, 4'd0, '0);
    check("R8", "setup pulse", int'(pulse), 1);
    cyc(1, 1, 0, 4'd2, 16'h0001);
    check("R8", "event wins pulse", int'(pulse), 1);
    read_reg(4'd0, v); check("R8", "flag stays set", v, 1);
    cyc(0, 1, 0, 4'd2, 16'h0001);
    check("R8", "nothing left pending", int'(pulse), 0);
    read_reg(4'd0, v); check("R8", "flag clear after", v, 0);

    // R6/R7: status write ignored, reserved and unmapped reads
    cur_req = "R7";
    cyc(0, 1, 0, 4'd0, 16'hFFFF);
    read_reg(4'd0, v); check("R6", "status write ignored", v, 0);
    read_reg(4'd6, v); check("R7", "unmapped reads zero", v, 0);
    cyc(0, 0, 0, 4'd0, '0);
    check("R7", "idle rdata zero", int'(rdata), 0);

    // Mixed traffic against the model
    cur_req = "R4";
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] & lfsr[3], lfsr[5] & lfsr[7], lfsr[9],
          {1'b0, lfsr[11] & lfsr[2], lfsr[4] & lfsr[8], 1'b0},
          {lfsr[15:1], lfsr[6]});
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule